// File: doc/BRIEF.md
# Quadrature Mixer with Dither and Output Attenuation

This block combines one complex baseband sample stream with a local oscillator to form a real modulated stream. Each clock it takes a signed I and Q word and a signed cosine and sine value. It narrows I and Q to the multiplier width and forms I·cos − Q·sin at full precision. It then attenuates the result in steps of 6 dB and delivers one rounded, clamped output word per clock. A valid flag travels with each sample through the pipeline.

I and Q can reach full scale together, so their combined magnitude can sit about 3 dB above full scale. The block therefore always removes at least 6 dB. A 2-bit code adds up to three further 6 dB steps. An optional dither can be switched on. It adds a pseudo-random value smaller than one multiplier LSB to I and Q before they are narrowed, which spreads the spurs that truncation would otherwise produce. Dither raises the error floor by roughly 3 dB, so it stays off unless the control word asks for it.

Top module: `quad_mixer`

## Requirements
- R1: Inputs are captured on a rising clock edge. The matching `out_data` and `out_valid` appear after the third rising edge, counting the capturing edge. A new sample can be accepted on every clock.
- R2: `out_valid` equals `in_valid` delayed by three clocks. While `rst_n` is low, `out_valid` and `out_data` read 0.
- R3: With dither off, I and Q are floored to their upper MUL_W bits by an arithmetic right shift of DIN_W−MUL_W places (2 at defaults). The output is round((tI·cos − tQ·sin) / 2^S), where tI and tQ are the floored words and exact ties round toward +infinity. S is (MUL_W+TRIG_W−OUT_W) + code, which is 14 to 17 at defaults. The result is clamped to the signed OUT_W range.
- R4: `in_ctrl[1:0]` is the attenuation code. Code 0 gives 6 dB of loss, code 1 gives 12 dB, code 2 gives 18 dB and code 3 gives 24 dB. Each step is one more place of right shift in R3.
- R5: `in_ctrl[3:2]` have no effect on the output.
- R6: Dither is on only when `in_ctrl[4]` is 1. When it is off, the output matches R3 exactly. When it is on, a pseudo-random value in [0, 2^(DIN_W−MUL_W) − 1] is added to I and to Q before flooring. The add saturates at the most positive input, and the values for I and Q come from separate bits of one LFSR. At defaults, the dithered output stays within 5 LSB of the R3 value, and some samples differ from it.
- R7: When I and Q are both 0, or cos and sin are both 0, the output is 0 for every attenuation code and dither setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the input sample as valid |
| in_i | input | DIN_W | Signed in-phase sample |
| in_q | input | DIN_W | Signed quadrature sample |
| in_cos | input | TRIG_W | Signed oscillator cosine |
| in_sin | input | TRIG_W | Signed oscillator sine |
| in_ctrl | input | 5 | [1:0] attenuation code, [3:2] no effect, [4] dither enable |
| out_valid | output | 1 | Valid flag aligned with `out_data` |
| out_data | output | OUT_W | Signed mixed, attenuated and clamped output |

## Verification
Full-scale negative I and Q are applied against extreme cosine and sine under each code. This separates an error in shift amount or sign handling from correct 6 dB steps. Directed ties at +0.5 and −0.5 LSB show whether rounding goes toward +infinity and not away from zero. Random words with random valid gaps and random reserved bits check exact arithmetic, valid alignment and the reserved bits having no effect. Dithered random words, a most-positive input and zero I/Q confirm that dither stays bounded, actually changes some results, saturates instead of wrapping, and cannot lift a zero input.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

    localparam int CTRL_W = 5;

    // control word layout: dither enable on top, two bits without effect, attenuation code at the bottom
    typedef struct packed {
        logic       dith;
        logic [1:0] rsvd;
        logic [1:0] scale;
    } qmix_ctrl_t;

endpackage

// File: rtl/mix_lfsr.sv
module mix_lfsr #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter int             OUT_B = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_B-1:0] rnd
);

    logic [W-1:0] state_d, state_q;

    // right-shifting Galois form, advances every clock
    always_comb begin
        state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= {{(W-1){1'b0}}, 1'b1};
        else        state_q <= state_d;
    end

    assign rnd = state_q[OUT_B-1:0];

endmodule

// File: rtl/mix_trunc.sv
module mix_trunc #(
    parameter int DIN_W  = 18,
    parameter int MUL_W  = 16,
    localparam int DROP   = DIN_W - MUL_W,
    localparam int DROP_B = (DROP > 0) ? DROP : 1
) (
    input  logic [DIN_W-1:0]  din,
    input  logic [DROP_B-1:0] rnd,
    input  logic              en,
    output logic [MUL_W-1:0]  dout
);

    if (DROP > 0) begin : g_dith
        logic signed [DIN_W:0] ext;
        logic signed [DIN_W:0] addend;
        logic [DIN_W-1:0]      clamped;
        logic                  unused_lsb;

        always_comb begin
            addend              = '0;
            addend[DROP_B-1:0]  = en ? rnd : '0;
            ext                 = $signed({din[DIN_W-1], din}) + addend;
            // only positive overflow is possible: clamp to most positive word
            if (ext[DIN_W] != ext[DIN_W-1]) clamped = {1'b0, {(DIN_W-1){1'b1}}};
            else                            clamped = ext[DIN_W-1:0];
        end

        assign dout       = clamped[DIN_W-1:DROP];
        assign unused_lsb = ^clamped[DROP-1:0];
    end else begin : g_pass
        logic unused_dith;
        assign dout        = din;
        assign unused_dith = ^{rnd, en};
    end

endmodule

// File: rtl/mix_scale.sv
module mix_scale #(
    parameter int SUM_W   = 33,
    parameter int OUT_W   = 18,
    parameter int BASE_SH = 14
) (
    input  logic [SUM_W-1:0] sum_in,
    input  logic [1:0]       code,
    output logic [OUT_W-1:0] y
);

    localparam logic [SUM_W-1:0] OMAX = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic [SUM_W-1:0] OMIN = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [SUM_W-1:0] ONE  = {{(SUM_W-1){1'b0}}, 1'b1};

    logic [SUM_W-1:0]        bias;
    logic signed [SUM_W-1:0] rnd_sum;
    logic signed [SUM_W-1:0] shifted;
    int                      sh;

    always_comb begin
        sh      = BASE_SH + int'(code);
        bias    = ONE << (sh - 1);
        rnd_sum = $signed(sum_in) + $signed(bias);
        shifted = rnd_sum >>> sh;
        if (shifted > $signed(OMAX))      y = OMAX[OUT_W-1:0];
        else if (shifted < $signed(OMIN)) y = OMIN[OUT_W-1:0];
        else                              y = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
    import qmix_pkg::*;
#(
    parameter int               DIN_W     = 18,
    parameter int               MUL_W     = 16,
    parameter int               TRIG_W    = 16,
    parameter int               OUT_W     = 18,
    parameter int               LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DIN_W-1:0]    in_i,
    input  logic [DIN_W-1:0]    in_q,
    input  logic [TRIG_W-1:0]   in_cos,
    input  logic [TRIG_W-1:0]   in_sin,
    input  logic [CTRL_W-1:0]   in_ctrl,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data
);

    localparam int DROP    = DIN_W - MUL_W;
    localparam int DROP_B  = (DROP > 0) ? DROP : 1;
    localparam int PROD_W  = MUL_W + TRIG_W;
    localparam int SUM_W   = PROD_W + 1;
    localparam int BASE_SH = PROD_W - OUT_W;

    typedef struct packed {
        logic              v1;
        logic [DIN_W-1:0]  i1;
        logic [DIN_W-1:0]  q1;
        logic [TRIG_W-1:0] c1;
        logic [TRIG_W-1:0] s1;
        logic              dith1;
        logic [1:0]        sc1;
        logic              v2;
        logic [PROD_W-1:0] pi2;
        logic [PROD_W-1:0] pq2;
        logic [1:0]        sc2;
        logic              v3;
        logic [OUT_W-1:0]  y3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    qmix_ctrl_t              ctl;
    logic                    unused_rsvd;
    logic [2*DROP_B-1:0]     dith_bits;
    logic [DIN_W-1:0]        lane_in  [2];
    logic [MUL_W-1:0]        lane_out [2];
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [SUM_W-1:0]  mix_sum;
    logic [OUT_W-1:0]         scaled;

    assign ctl         = qmix_ctrl_t'(in_ctrl);
    assign unused_rsvd = ^ctl.rsvd;

    mix_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .OUT_B(2*DROP_B)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (dith_bits)
    );

    assign lane_in[0] = pipe_q.i1;
    assign lane_in[1] = pipe_q.q1;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        mix_trunc #(.DIN_W(DIN_W), .MUL_W(MUL_W)) u_trunc (
            .din  (lane_in[g]),
            .rnd  (dith_bits[g*DROP_B +: DROP_B]),
            .en   (pipe_q.dith1),
            .dout (lane_out[g])
        );
    end

    mix_scale #(.SUM_W(SUM_W), .OUT_W(OUT_W), .BASE_SH(BASE_SH)) u_scale (
        .sum_in (mix_sum),
        .code   (pipe_q.sc2),
        .y      (scaled)
    );

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: capture
        pipe_d.v1    = in_valid;
        pipe_d.i1    = in_i;
        pipe_d.q1    = in_q;
        pipe_d.c1    = in_cos;
        pipe_d.s1    = in_sin;
        pipe_d.dith1 = ctl.dith;
        pipe_d.sc1   = ctl.scale;

        // stage 2: narrowed data times oscillator
        prod_i     = PROD_W'($signed(lane_out[0])) * PROD_W'($signed(pipe_q.c1));
        prod_q     = PROD_W'($signed(lane_out[1])) * PROD_W'($signed(pipe_q.s1));
        pipe_d.v2  = pipe_q.v1;
        pipe_d.pi2 = prod_i;
        pipe_d.pq2 = prod_q;
        pipe_d.sc2 = pipe_q.sc1;

        // stage 3: difference, attenuate, round, clamp
        mix_sum   = SUM_W'($signed(pipe_q.pi2)) - SUM_W'($signed(pipe_q.pq2));
        pipe_d.v3 = pipe_q.v2;
        pipe_d.y3 = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.v3;
    assign out_data  = pipe_q.y3;

endmodule

// File: rtl/qmix_chk.sv
module qmix_chk #(
    parameter int DIN_W  = 18,
    parameter int TRIG_W = 16,
    parameter int OUT_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DIN_W-1:0]  in_i,
    input logic [DIN_W-1:0]  in_q,
    input logic [TRIG_W-1:0] in_cos,
    input logic [TRIG_W-1:0] in_sin,
    input logic [4:0]        in_ctrl,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data
);

    logic [2:0] age_q;
    logic       unused_bits;

    assign unused_bits = ^in_ctrl[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd3) |-> (out_valid == $past(in_valid, 3)));

    // R7
    zero_iq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && $past(in_i, 3) == '0 && $past(in_q, 3) == '0) |-> (out_data == '0));

    // R7
    zero_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && $past(in_cos, 3) == '0 && $past(in_sin, 3) == '0) |-> (out_data == '0));

    // R6
    dith_off_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5
         && $past({in_i, in_q, in_cos, in_sin, in_ctrl[1:0]}, 3) == $past({in_i, in_q, in_cos, in_sin, in_ctrl[1:0]}, 4)
         && !$past(in_ctrl[4], 3) && !$past(in_ctrl[4], 4))
        |-> $stable(out_data));

endmodule

bind quad_mixer qmix_chk #(.DIN_W(DIN_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W)) u_qmix_chk (.*);

// File: tb/test_quad_mixer.sv
`timescale 1ns/1ps
module test_quad_mixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_i = '0, in_q = '0;
    logic [15:0] in_cos = '0, in_sin = '0;
    logic [4:0]  in_ctrl = '0;
    logic        out_valid;
    logic [17:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    int n_dith_diff = 0;
    int cyc = 0;
    bit done = 1'b0;

    // expectation ring, indexed by step number modulo 4
    bit     e_v    [4];
    longint e_y    [4];
    int     e_mode [4];
    string  e_req  [4];

    always #2 clk = ~clk;

    quad_mixer i_quad_mixer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .in_cos(in_cos), .in_sin(in_sin),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint model(longint i, longint q, longint c, longint s, int code);
        longint ti, tq, sum, r;
        int sh;
        ti  = i >>> 2;
        tq  = q >>> 2;
        sum = ti * c - tq * s;
        sh  = 14 + code;
        r   = (sum + (64'sd1 <<< (sh - 1))) >>> sh;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    // mode 0: exact, mode 1: dithered within 5 LSB
    task automatic step(input longint i, input longint q, input longint c, input longint s,
                        input logic [4:0] k, input bit v, input int mode, input string req);
        int     ci, wi;
        longint got, dif;
        @(negedge clk);
        ci = (cyc + 1) % 4;
        wi = cyc % 4;
        n_cmp++;
        if (out_valid !== e_v[ci]) begin
            n_bad++;
            $display("FAIL R2 valid alignment: out_valid=%0b exp=%0b", out_valid, e_v[ci]);
        end
        if (e_v[ci]) begin
            got = longint'($signed(out_data));
            n_cmp++;
            if (e_mode[ci] == 0) begin
                if (got != e_y[ci]) begin
                    n_bad++;
                    $display("FAIL %s: out=%0d exp=%0d", e_req[ci], got, e_y[ci]);
                end
            end else begin
                dif = got - e_y[ci];
                if (dif != 0) n_dith_diff++;
                if (dif > 5 || dif < -5) begin
                    n_bad++;
                    $display("FAIL %s dither bound: out=%0d exp=%0d+-5", e_req[ci], got, e_y[ci]);
                end
            end
        end
        in_i     = i[17:0];
        in_q     = q[17:0];
        in_cos   = c[15:0];
        in_sin   = s[15:0];
        in_ctrl  = k;
        in_valid = v;
        e_v[wi]    = v;
        e_y[wi]    = model(i, q, c, s, int'(k[1:0]));
        e_mode[wi] = mode;
        e_req[wi]  = req;
        cyc++;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic signed [17:0] ri, rq;
        logic signed [15:0] rc, rs;
        logic [4:0] rk;
        void'($urandom(32'd4242));
        for (int n = 0; n < 4; n++) begin
            e_v[n] = 1'b0; e_y[n] = 0; e_mode[n] = 0; e_req[n] = "";
        end

        repeat (5) @(negedge clk);
        // R2: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R2 reset: valid=%0b data=%0d exp=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;

        // R3/R4: full-scale corners under every attenuation code
        for (int k = 0; k < 4; k++) begin
            step(-131072, -131072, -32768, 32767, 5'(k), 1'b1, 0, "R4 full scale code");
            step(131071, -131072, 32767, -32768, 5'(k), 1'b1, 0, "R4 full scale mix");
            step(131071, 0, 12345, 0, 5'(k), 1'b1, 0, "R4 ladder");
        end
        // R3: rounding ties, positive and negative
        step(4, 0, 8192, 0, 5'd0, 1'b1, 0, "R3 tie up");
        step(4, 0, -8192, 0, 5'd0, 1'b1, 0, "R3 tie neg");
        step(0, 4, 0, 8192, 5'd0, 1'b1, 0, "R3 tie q");
        step(-1, 0, 32767, 0, 5'd0, 1'b1, 0, "R3 floor neg");

        // R5: reserved bits toggled over the same sample
        for (int k = 0; k < 4; k++)
            step(77777, -55555, 23456, -7890, {1'b0, 2'(k), 2'd1}, 1'b1, 0, "R5 reserved bits");

        // R1/R3/R5: random stream with gaps, dither off
        for (int n = 0; n < 3000; n++) begin
            ri = 18'($urandom()); rq = 18'($urandom());
            rc = 16'($urandom()); rs = 16'($urandom());
            rk = 5'($urandom()) & 5'h0F;
            step(longint'(ri), longint'(rq), longint'(rc), longint'(rs), rk,
                 ($urandom() % 4) != 0, 0, "R3 random");
        end

        // R7: zero I/Q and zero oscillator under dither and all codes
        for (int k = 0; k < 4; k++) begin
            step(0, 0, -32768, 32767, {3'b100, 2'(k)}, 1'b1, 0, "R7 zero iq");
            step(131071, -131072, 0, 0, {3'b110, 2'(k)}, 1'b1, 0, "R7 zero trig");
        end

        // R6: saturation of the dither add at the most positive input
        for (int n = 0; n < 8; n++)
            step(131071, 131071, 32767, -32768, 5'b10000, 1'b1, 0, "R6 dither saturate");

        // R6: dithered random stream
        n_dith_diff = 0;
        for (int n = 0; n < 3000; n++) begin
            ri = 18'($urandom()); rq = 18'($urandom());
            rc = 16'($urandom()); rs = 16'($urandom());
            step(longint'(ri), longint'(rq), longint'(rc), longint'(rs),
                 {1'b1, 2'($urandom()), 2'($urandom())}, 1'b1, 1, "R6 dither random");
        end
        for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 5'd0, 1'b0, 0, "R1 flush");

        // R6: dither must change at least some results
        n_cmp++;
        if (n_dith_diff == 0) begin
            n_bad++;
            $display("FAIL R6 dither inactive: differing=%0d exp=>0", n_dith_diff);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule